// File: doc/BRIEF.md
# I2C Write-Only Control Register Slave

This block is an I2C slave that only accepts writes. It fills a bank of control registers that set DAC levels and switch bits. SCL and SDA come in as plain levels. The block drives SDA through an output enable that pulls the open-drain line low. Both lines are brought into the system clock domain and watched for bus conditions and clock edges.

Every transaction starts with the device address byte. The next byte is a sub-address. Bit 7 of the sub-address sets how the data bytes that follow are stored:

- With bit 7 clear, they fill consecutive registers.
- With bit 7 set, they all land on the same register.

Register contents after reset are zero, and the host is expected to load every value it needs.

Top module: `i2c_wr_regbank`

## Requirements
- R1: During and after reset, all register outputs (`dac_vals`, `sw_bits`) are zero and `sda_oe` is 0.
- R2: An address byte equal to 8'h8A (7-bit address 7'h45 followed by write bit 0) is acknowledged by pulling SDA low during the ninth SCL clock.
- R3: The acknowledge drive (`sda_oe`=1) starts after the SCL falling edge that ends the eighth bit and ends after the SCL falling edge that ends the ninth clock.
- R4: Any other address byte, including 8'h8B (read), is not acknowledged. After it, no byte is acknowledged and no register changes until the next start condition.
- R5: When sub-address bit 7 is 0, data byte k of the transaction goes to register index (sub-address[6:0] + k).
- R6: When sub-address bit 7 is 1, every data byte of the transaction goes to register index sub-address[6:0].
- R7: In increment mode the index wraps from the last register, index 16, to index 0. An index of 17 or more also steps to 0.
- R8: A stop or a repeated start in the middle of a byte drops that byte and leaves all earlier writes in place. After a repeated start, the next address byte is decoded normally.
- R9: Register indices 0..14 drive `dac_vals[8i+7:8i]`. Index 15 drives `sw_bits[7:0]`. Bits 4..0 of index 16 drive `sw_bits[12:8]`. Writes to indices 17..127 are acknowledged but change nothing.
- R10: Once the address has matched, every sub-address and data byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| dac_vals | output | NUM_DAC*8 | DAC control bytes, index 0 in the low byte |
| sw_bits | output | NUM_SW | Switch control bits |

## Verification
Two events can meet on the same SCL falling edge:

- the register write that a completed data byte causes;
- the acknowledge drive the slave starts on that edge.

The bench checks both after each byte. It confirms that the acknowledge was sampled in the ninth clock and that the register bank already holds the new value at the end of that clock.

A stop or a repeated start can also arrive where an SCL edge for the next bit is expected. The bench provokes this by cutting a byte off after a few bits. It then compares the whole register bank against its model, to show that the cut byte was dropped and that earlier writes remain.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } rx_state_t;

  // number of byte registers needed for the DAC bytes plus packed switch bits
  function automatic int bank_depth(input int n_dac, input int n_sw);
    return n_dac + (n_sw + 7) / 8;
  endfunction

  // stored width of register k
  function automatic int reg_width(input int k, input int n_dac, input int n_sw);
    int rem;
    if (k < n_dac) return 8;
    rem = n_sw - 8 * (k - n_dac);
    return (rem > 8) ? 8 : rem;
  endfunction

  // increment-mode successor, wrapping after the last implemented index
  function automatic logic [6:0] step_index(input logic [6:0] cur, input int last);
    return (cur >= 7'(last)) ? 7'd0 : cur + 7'd1;
  endfunction

  function automatic logic addr_write_match(input logic [7:0] b, input logic [6:0] dev);
    return b == {dev, 1'b0};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter int         LAST_IDX = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  output logic       sda_oe,
  output logic       ack_phase,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data
);
  rx_state_t  state;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic [6:0] ptr;
  logic       refresh;
  logic       active;

  assign active = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      ptr       <= '0;
      refresh   <= 1'b0;
      sda_oe    <= 1'b0;
      ack_phase <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        ack_phase <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        ack_phase <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (active) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (ack_phase) begin
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
            bit_cnt   <= '0;
          end else if (bit_cnt == 4'd8) begin
            unique case (state)
              ST_ADDR: begin
                if (addr_write_match(shreg, DEV_ADDR)) begin
                  sda_oe    <= 1'b1;
                  ack_phase <= 1'b1;
                  state     <= ST_SUB;
                end else begin
                  state   <= ST_SKIP;
                  bit_cnt <= '0;
                end
              end
              ST_SUB: begin
                sda_oe    <= 1'b1;
                ack_phase <= 1'b1;
                ptr       <= shreg[6:0];
                refresh   <= shreg[7];
                state     <= ST_DATA;
              end
              default: begin
                sda_oe    <= 1'b1;
                ack_phase <= 1'b1;
                wr_en     <= 1'b1;
                wr_idx    <= ptr;
                wr_data   <= shreg;
                if (!refresh) ptr <= step_index(ptr, LAST_IDX);
              end
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rb_pkg::*;
#(
  parameter int NUM_DAC = 15,
  parameter int NUM_SW  = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [6:0]           wr_idx,
  input  logic [7:0]           wr_data,
  output logic [NUM_DAC*8-1:0] dac_vals,
  output logic [NUM_SW-1:0]    sw_bits
);
  localparam int DEPTH = bank_depth(NUM_DAC, NUM_SW);

  for (genvar k = 0; k < DEPTH; k++) begin : g_reg
    localparam int W = reg_width(k, NUM_DAC, NUM_SW);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (wr_en && wr_idx == 7'(k))   q <= wr_data[W-1:0];
    end

    if (k < NUM_DAC) begin : g_dac
      assign dac_vals[8*k +: 8] = q;
    end else begin : g_sw
      assign sw_bits[8*(k-NUM_DAC) +: W] = q;
    end
  end

endmodule

// File: rtl/i2c_wr_regbank.sv
module i2c_wr_regbank
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter int         NUM_DAC     = 15,
  parameter int         NUM_SW      = 13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic [NUM_DAC*8-1:0] dac_vals,
  output logic [NUM_SW-1:0]    sw_bits
);
  localparam int DEPTH    = bank_depth(NUM_DAC, NUM_SW);
  localparam int LAST_IDX = DEPTH - 1;

  logic       sda_lvl_w;
  logic       scl_rise_w;
  logic       scl_fall_w;
  logic       start_evt_w;
  logic       stop_evt_w;
  logic       ack_phase_w;
  logic       wr_en_w;
  logic [6:0] wr_idx_w;
  logic [7:0] wr_data_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .sda_lvl  (sda_lvl_w),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start_evt(start_evt_w),
    .stop_evt (stop_evt_w)
  );

  i2c_rx_engine #(.DEV_ADDR(DEV_ADDR), .LAST_IDX(LAST_IDX)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_lvl_w),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start_evt(start_evt_w),
    .stop_evt (stop_evt_w),
    .sda_oe   (sda_oe),
    .ack_phase(ack_phase_w),
    .wr_en    (wr_en_w),
    .wr_idx   (wr_idx_w),
    .wr_data  (wr_data_w)
  );

  i2c_reg_bank #(.NUM_DAC(NUM_DAC), .NUM_SW(NUM_SW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_w),
    .wr_idx  (wr_idx_w),
    .wr_data (wr_data_w),
    .dac_vals(dac_vals),
    .sw_bits (sw_bits)
  );

endmodule

// File: rtl/i2c_wr_regbank_chk.sv
module i2c_wr_regbank_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic ack_phase,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic wr_en
);
  assert_ack_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_ack_release_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  assert_oe_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_phase);

  assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall));

  assert_write_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && !wr_en));

endmodule

bind i2c_wr_regbank i2c_wr_regbank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .ack_phase(ack_phase_w),
  .scl_fall (scl_fall_w),
  .start_evt(start_evt_w),
  .stop_evt (stop_evt_w),
  .wr_en    (wr_en_w)
);

// File: tb/test_i2c_wr_regbank.sv
module test_i2c_wr_regbank;
  localparam int NDAC  = 15;
  localparam int NSW   = 13;
  localparam int DEPTH = 17;
  localparam int Q     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_oe;
  wire  [NDAC*8-1:0] dac;
  wire  [NSW-1:0]    sw;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_wr_regbank i_i2c_wr_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dac_vals(dac), .sw_bits(sw)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] pay [20];
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    logic [NSW-1:0] exp_sw;
    bit ok;
    int first;
    ok = 1;
    first = -1;
    for (int i = 0; i < NDAC; i++)
      if (dac[8*i +: 8] !== model[i] && ok) begin ok = 0; first = i; end
    exp_sw = {model[16][4:0], model[15]};
    if (ok && sw !== exp_sw) begin
      ok = 0;
      chk(0, req, "switch bits", 32'(sw), 32'(exp_sw));
    end else if (!ok) begin
      chk(0, req, $sformatf("dac index %0d", first), 32'(dac[8*first +: 8]), 32'(model[first]));
    end else begin
      chk(1, req, "bank", 0, 0);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0;
    end
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked,
                           output bit oe_before, output bit oe_after);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q);
    oe_before = sda_oe;
    scl_m = 1'b1; tick(Q);
    acked = !sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
    oe_after = sda_oe;
  endtask

  // model update from R5/R6/R7/R9
  task automatic write_txn(input logic [7:0] sub, input int n, input string req);
    bit a, ob, oa;
    logic [6:0] idx;
    idx = sub[6:0];
    bus_start;
    send_byte(8'h8A, a, ob, oa);
    chk(a, "R2", "address ack", 32'(a), 1);
    chk(ob && !oa, "R3", "ack window", {30'd0, ob, oa}, 2);
    send_byte(sub, a, ob, oa);
    chk(a, "R10", "sub-address ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(pay[k], a, ob, oa);
      chk(a && ob && !oa, "R10", "data ack", {29'd0, a, ob, oa}, 6);
      if (idx < 7'(DEPTH)) model[idx] = pay[k];
      if (!sub[7]) idx = (idx >= 7'(DEPTH - 1)) ? 7'd0 : idx + 7'd1;
      check_bank(req);
    end
    bus_stop;
  endtask

  initial begin
    bit a, ob, oa;
    logic [7:0] bad_addr;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

    // R1 reset
    tick(5);
    chk(sda_oe == 1'b0, "R1", "sda_oe in reset", 32'(sda_oe), 0);
    chk(dac == '0 && sw == '0, "R1", "outputs in reset", 32'(sw), 0);
    rst_n = 1'b1;
    tick(4);
    check_bank("R1");

    // R5 / R7: increment sweep from every start index, three bytes each
    for (int s = 0; s < DEPTH; s++) begin
      for (int k = 0; k < 3; k++) pay[k] = 8'((s * 29 + k * 71 + 3) & 255);
      write_txn(8'(s), 3, (s >= DEPTH - 2) ? "R7" : "R5");
    end

    // R9: full bank in one transaction
    for (int k = 0; k < DEPTH; k++) pay[k] = 8'((k * 53 + 17) & 255);
    write_txn(8'h00, DEPTH, "R9");
    chk(sw[12:8] == pay[16][4:0], "R9", "upper switch field", 32'(sw[12:8]), 32'(pay[16][4:0]));

    // R6: refresh mode, four bytes to one index
    foreach (pay[k]) pay[k] = 8'((k * 97 + 201) & 255);
    write_txn(8'h80, 4, "R6");
    write_txn(8'h87, 4, "R6");
    write_txn(8'h8F, 4, "R6");
    write_txn(8'h90, 4, "R6");

    // R9: out-of-range index ignored, then increment wraps to 0 (R7)
    pay[0] = 8'hE1; pay[1] = 8'h5C;
    write_txn(8'h14, 2, "R9");
    chk(dac[7:0] == 8'h5C, "R7", "wrap from out-of-range index", 32'(dac[7:0]), 32'h5C);

    // R4: every single-bit corruption of the address byte (bit 0 is the read request)
    for (int b = 0; b < 8; b++) begin
      bad_addr = 8'h8A ^ (8'h01 << b);
      bus_start;
      send_byte(bad_addr, a, ob, oa);
      chk(!a, "R4", $sformatf("no ack for %02h", bad_addr), 32'(a), 0);
      send_byte(8'h02, a, ob, oa);
      chk(!a, "R4", "no ack for later byte", 32'(a), 0);
      send_byte(8'h5A, a, ob, oa);
      chk(!a, "R4", "no ack for data", 32'(a), 0);
      bus_stop;
      check_bank("R4");
    end

    // R8: stop in mid byte
    bus_start;
    send_byte(8'h8A, a, ob, oa);
    send_byte(8'h03, a, ob, oa);
    send_byte(8'hC3, a, ob, oa);
    model[3] = 8'hC3;
    send_bits(8'hFF, 4);
    bus_stop;
    chk(sda_oe == 1'b0, "R8", "released after stop", 32'(sda_oe), 0);
    check_bank("R8");

    // R8: repeated start in mid byte, then a normal transaction
    bus_start;
    send_byte(8'h8A, a, ob, oa);
    send_byte(8'h09, a, ob, oa);
    send_byte(8'h11, a, ob, oa);
    model[9] = 8'h11;
    send_bits(8'h00, 3);
    bus_start;
    send_byte(8'h8A, a, ob, oa);
    chk(a, "R8", "address ack after repeated start", 32'(a), 1);
    send_byte(8'h0A, a, ob, oa);
    send_byte(8'h22, a, ob, oa);
    model[10] = 8'h22;
    bus_stop;
    check_bank("R8");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule